// File: doc/BRIEF.md
# Region-Indexed Address Translator

This block turns 32-bit virtual addresses into physical addresses for a machine with 512-byte pages. The two top bits of an address pick one of four 1 GiB regions. Two regions belong to the running process, one is the system region shared by every process, and the fourth is reserved. Each of the three usable regions has one flat page table, given by a start address and a length in entries. The low nine bits are the byte offset, and they are carried through unchanged.

A request first looks in a small fully associative translation cache. If it misses and the page number is inside the region's bounds, the block computes the entry address directly as table start plus four times the page number. It then reads that single 32-bit entry over a valid/ready memory port, returns the translation and fills the cache using round-robin replacement. The second process region is filled from the top down, so its length check is reversed. Writing a region's start or length register drops every cached entry of that region. A process switch therefore only rewrites the two process-region pairs.

Top module: `rx_walker`

## Requirements
- R1: For every successful translation, `rsp_pa[8:0]` equals bits 8:0 of the accepted virtual address.
- R2: An address with `req_va[31:30]` = 3 completes one cycle after acceptance with `rsp_code` = 2 and issues no memory read.
- R3: In regions 0 and 2, a page number (`req_va[29:9]`) not below the region length register completes one cycle after acceptance with `rsp_code` = 1 and no memory read.
- R4: In region 1, a page number below the length register faults with `rsp_code` = 1 and no memory read. A page number equal to or above it is valid.
- R5: The entry read on a miss is at the region's start register plus four times the page number. Regions are selected by `req_va[31:30]` (0, 1, 2) and by `cfg_region` for writes, with `cfg_is_len` = 1 choosing the length register. A request stays on the port with a stable address until it is accepted.
- R6: A miss issues exactly one memory read. One cycle after `mem_rsp_valid`, `rsp_done` pulses with `rsp_code` = 0 and `rsp_pa` = {entry[20:0], offset}. Entry bits 30:21 are ignored.
- R7: A repeat access to a cached page completes one cycle after acceptance with no memory read.
- R8: An entry with bit 31 clear yields `rsp_code` = 3 and is not cached, so a repeat access reads memory again.
- R9: A write to a region's start or length register removes that region's cached pages. Pages of other regions still hit.
- R10: If a region's register is written while a read for that region is outstanding, the returned entry is delivered but not cached.
- R11: Fills replace cache entries in round-robin order. With N entries, the (N+1)th fill evicts the first page filled.
- R12: After reset `req_ready` is 1 and `rsp_done` and `mem_req_valid` are 0. `req_ready` stays 0 while a memory read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_region | input | 2 | Region of the written register (0, 1, 2; 3 ignored) |
| cfg_is_len | input | 1 | 1 writes the length register, 0 the start register |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle and accepting a request |
| req_va | input | 32 | Virtual address |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_code | output | 2 | 0 ok, 1 length, 2 reserved region, 3 invalid entry |
| rsp_pa | output | 30 | Physical address, valid when code is 0 |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Page table entry |

## Verification
The hardest case to reach from the ports is a register write that lands while a table read is still in flight. From the outside, the only trace it leaves is a later miss on a page that would otherwise have been cached. The bench's translation task can place a write to the requesting region in the same cycle it first sees the memory request. It then repeats the access and expects a second read. Round-robin eviction is reached with a four-entry instance, so a handful of fills is enough to wrap the replacement pointer.

// File: rtl/rx_pkg.sv
package rx_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 9;
    localparam int VPN_W  = VA_W - 2 - OFF_W;
    localparam int PFN_W  = 21;
    localparam int PA_W   = PFN_W + OFF_W;
    localparam int NREG   = 3;

    typedef enum logic [1:0] {RG_P0 = 2'd0, RG_P1 = 2'd1, RG_S0 = 2'd2, RG_RSV = 2'd3} region_e;
    typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_LEN = 2'd1, FLT_RSV = 2'd2, FLT_INV = 2'd3} fault_e;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_FETCH = 2'd1, ST_WAIT = 2'd2} walk_st_e;
endpackage

// File: rtl/rx_regs.sv
module rx_regs
    import rx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_region,
    input  logic              wr_is_len,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [1:0]        rd_region,
    output logic [ADDR_W-1:0] rd_base,
    output logic [ADDR_W-1:0] rd_len,
    output logic              inv_en,
    output logic [1:0]        inv_region
);
    logic [ADDR_W-1:0] base_q [NREG];
    logic [ADDR_W-1:0] base_d [NREG];
    logic [ADDR_W-1:0] len_q  [NREG];
    logic [ADDR_W-1:0] len_d  [NREG];

    always_comb begin
        rd_base = '0;
        rd_len  = '0;
        for (int r = 0; r < NREG; r++) begin
            base_d[r] = base_q[r];
            len_d[r]  = len_q[r];
            if (wr_en && wr_region == 2'(r)) begin
                if (wr_is_len) len_d[r]  = wr_data;
                else           base_d[r] = wr_data;
            end
            if (rd_region == 2'(r)) begin
                rd_base = base_q[r];
                rd_len  = len_q[r];
            end
        end
        inv_en     = wr_en && (wr_region < 2'(NREG));
        inv_region = wr_region;
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < NREG; r++) begin
            if (!rst_n) begin
                base_q[r] <= '0;
                len_q[r]  <= '0;
            end else begin
                base_q[r] <= base_d[r];
                len_q[r]  <= len_d[r];
            end
        end
    end
endmodule

// File: rtl/rx_tlb.sv
module rx_tlb #(
    parameter int ENTRIES = 128,
    parameter int VPN_W   = 21,
    parameter int PFN_W   = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       lk_region,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             fill_en,
    input  logic [1:0]       fill_region,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             inv_en,
    input  logic [1:0]       inv_region
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld_q, vld_d, match;
    logic [1:0]         rg_q  [ENTRIES];
    logic [1:0]         rg_d  [ENTRIES];
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [VPN_W-1:0]   vpn_d [ENTRIES];
    logic [PFN_W-1:0]   pfn_q [ENTRIES];
    logic [PFN_W-1:0]   pfn_d [ENTRIES];
    logic [IDX_W-1:0]   ptr_q, ptr_d;

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
        assign match[gi] = vld_q[gi] && (rg_q[gi] == lk_region) && (vpn_q[gi] == lk_vpn);
    end

    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) lk_pfn = lk_pfn | pfn_q[i];
        end
        lk_hit = |match;
    end

    always_comb begin
        vld_d = vld_q;
        ptr_d = ptr_q;
        for (int i = 0; i < ENTRIES; i++) begin
            rg_d[i]  = rg_q[i];
            vpn_d[i] = vpn_q[i];
            pfn_d[i] = pfn_q[i];
            if (inv_en && rg_q[i] == inv_region) vld_d[i] = 1'b0;
            if (fill_en && ptr_q == IDX_W'(i)) begin
                vld_d[i] = 1'b1;
                rg_d[i]  = fill_region;
                vpn_d[i] = fill_vpn;
                pfn_d[i] = fill_pfn;
            end
        end
        if (fill_en) ptr_d = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else begin
            vld_q <= vld_d;
            ptr_q <= ptr_d;
        end
        for (int i = 0; i < ENTRIES; i++) begin
            rg_q[i]  <= rg_d[i];
            vpn_q[i] <= vpn_d[i];
            pfn_q[i] <= pfn_d[i];
        end
    end
endmodule

// File: rtl/rx_walker.sv
module rx_walker
    import rx_pkg::*;
#(
    parameter int TLB_ENTRIES = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_region,
    input  logic             cfg_is_len,
    input  logic [VA_W-1:0]  cfg_wdata,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_va,
    output logic             rsp_done,
    output logic [1:0]       rsp_code,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [VA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [VA_W-1:0]  mem_rsp_data
);
    typedef struct packed {
        walk_st_e         st;
        logic [1:0]       rg;
        logic [VPN_W-1:0] vpn;
        logic [OFF_W-1:0] off;
        logic [VA_W-1:0]  pte_addr;
        logic             stale;
        logic             done;
        fault_e           code;
        logic [PA_W-1:0]  pa;
    } walk_t;

    walk_t q, d;

    logic [1:0]       va_rg;
    logic [VPN_W-1:0] va_vpn;
    logic [OFF_W-1:0] va_off;
    logic [VA_W-1:0]  rd_base, rd_len;
    logic             inv_en, lk_hit, len_ok, fill_en, cfg_hits_walk;
    logic [1:0]       inv_region;
    logic [PFN_W-1:0] lk_pfn;
    logic             unused_pte_bits;

    assign va_rg  = req_va[VA_W-1 -: 2];
    assign va_vpn = req_va[OFF_W +: VPN_W];
    assign va_off = req_va[OFF_W-1:0];
    assign unused_pte_bits = ^mem_rsp_data[VA_W-2:PFN_W];

    rx_regs #(.ADDR_W(VA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_region(cfg_region), .wr_is_len(cfg_is_len), .wr_data(cfg_wdata),
        .rd_region(va_rg), .rd_base(rd_base), .rd_len(rd_len),
        .inv_en(inv_en), .inv_region(inv_region)
    );

    rx_tlb #(.ENTRIES(TLB_ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_region(va_rg), .lk_vpn(va_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
        .fill_en(fill_en), .fill_region(q.rg), .fill_vpn(q.vpn),
        .fill_pfn(mem_rsp_data[PFN_W-1:0]),
        .inv_en(inv_en), .inv_region(inv_region)
    );

    // top-down region accepts pages at or above its length; the others below it
    assign len_ok = (va_rg == RG_P1) ? (VA_W'(va_vpn) >= rd_len) : (VA_W'(va_vpn) < rd_len);
    assign cfg_hits_walk = cfg_we && (cfg_region == q.rg);
    assign fill_en = (q.st == ST_WAIT) && mem_rsp_valid && mem_rsp_data[VA_W-1]
                     && !q.stale && !cfg_hits_walk;

    always_comb begin
        d = q;
        d.done = 1'b0;
        if (q.st != ST_IDLE && cfg_hits_walk) d.stale = 1'b1;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.rg    = va_rg;
                    d.vpn   = va_vpn;
                    d.off   = va_off;
                    d.stale = 1'b0;
                    d.pa    = '0;
                    d.code  = FLT_NONE;
                    if (va_rg == RG_RSV) begin
                        d.done = 1'b1;
                        d.code = FLT_RSV;
                    end else if (!len_ok) begin
                        d.done = 1'b1;
                        d.code = FLT_LEN;
                    end else if (lk_hit) begin
                        d.done = 1'b1;
                        d.pa   = {lk_pfn, va_off};
                    end else begin
                        d.st       = ST_FETCH;
                        d.pte_addr = rd_base + VA_W'({va_vpn, 2'b00});
                    end
                end
            end
            ST_FETCH: begin
                if (mem_req_ready) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    if (mem_rsp_data[VA_W-1]) d.pa = {mem_rsp_data[PFN_W-1:0], q.off};
                    else                      d.code = FLT_INV;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign rsp_done      = q.done;
    assign rsp_code      = q.code;
    assign rsp_pa        = q.pa;
    assign mem_req_valid = (q.st == ST_FETCH);
    assign mem_req_addr  = q.pte_addr;
endmodule

// File: rtl/rx_walker_chk.sv
module rx_walker_chk
    import rx_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_va,
    input logic            rsp_done,
    input logic [1:0]      rsp_code,
    input logic [PA_W-1:0] rsp_pa,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [VA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid
);
    logic [OFF_W-1:0] acc_off_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                      acc_off_q <= '0;
        else if (req_valid && req_ready) acc_off_q <= req_va[OFF_W-1:0];
    end

    assert_offset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_code == FLT_NONE) |-> (rsp_pa[OFF_W-1:0] == acc_off_q));

    assert_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_va[VA_W-1 -: 2] == RG_RSV)
        |=> (rsp_done && rsp_code == FLT_RSV && !mem_req_valid));

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_single_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    assert_done_after_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && !req_ready && !mem_req_valid) |=> rsp_done);

    assert_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);
endmodule

bind rx_walker rx_walker_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rsp_done(rsp_done), .rsp_code(rsp_code), .rsp_pa(rsp_pa),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/rx_walker_bench.sv
module rx_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_region = 2'd0;
    logic        cfg_is_len = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        rsp_done;
    logic [1:0]  rsp_code;
    logic [29:0] rsp_pa;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    rx_walker #(.TLB_ENTRIES(4)) u_rx_walker (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_region(cfg_region), .cfg_is_len(cfg_is_len), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .rsp_done(rsp_done), .rsp_code(rsp_code), .rsp_pa(rsp_pa),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // fields: va, pte, reads, entry address, code, pa
    localparam int NV = 12;
    localparam logic [129:0] VEC [NV] = '{
        {32'h0000_0A34, 32'h8000_0123, 2'd1, 32'h0001_0014, 2'd0, 30'h0002_4634},
        {32'h0000_0A00, 32'h0000_0000, 2'd0, 32'h0000_0000, 2'd0, 30'h0002_4600},
        {32'h0000_2000, 32'h0000_0000, 2'd0, 32'h0000_0000, 2'd1, 30'h0},
        {32'h0000_1E00, 32'h0000_0055, 2'd1, 32'h0001_003C, 2'd3, 30'h0},
        {32'h0000_1E00, 32'h0000_0055, 2'd1, 32'h0001_003C, 2'd3, 30'h0},
        {32'h7FFF_FFFF, 32'h8000_0ABC, 2'd1, 32'h0081_FFFC, 2'd0, 30'h0015_79FF},
        {32'h4000_0000, 32'h0000_0000, 2'd0, 32'h0000_0000, 2'd1, 30'h0},
        {32'h7FFF_E000, 32'h8000_0001, 2'd1, 32'h0081_FFC0, 2'd0, 30'h0000_0200},
        {32'h8000_0E10, 32'h8FFF_FFFF, 2'd1, 32'h0003_001C, 2'd0, 30'h3FFF_FE10},
        {32'h8000_1000, 32'h0000_0000, 2'd0, 32'h0000_0000, 2'd1, 30'h0},
        {32'hC000_1234, 32'h0000_0000, 2'd0, 32'h0000_0000, 2'd2, 30'h0},
        {32'h7FFF_FE00, 32'h0000_0000, 2'd0, 32'h0000_0000, 2'd0, 30'h0015_7800}
    };
    localparam string TAG [NV] = '{"R6", "R7", "R3", "R8", "R8", "R5",
                                   "R4", "R4", "R1", "R3", "R2", "R7"};

    int          got_reads, got_lat;
    logic [1:0]  got_code;
    logic [29:0] got_pa;
    logic [31:0] got_addr;
    logic        ready_in_fetch = 1'b0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] rg, input logic is_len, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_region = rg; cfg_is_len = is_len; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic xlate(input logic [31:0] va, input logic [31:0] pte,
                         input bit poke, input logic [31:0] poke_base);
        bit done = 0;
        bit pending = 0;
        @(negedge clk);
        req_valid = 1'b1; req_va = va;
        @(negedge clk);
        req_valid = 1'b0;
        got_reads = 0; got_lat = 99; got_code = 2'd0; got_pa = '0; got_addr = '0;
        for (int i = 1; i <= 12 && !done; i++) begin
            if (i > 1) @(negedge clk);
            mem_rsp_valid = 1'b0;
            cfg_we = 1'b0;
            if (rsp_done) begin
                done = 1; got_lat = i; got_code = rsp_code; got_pa = rsp_pa;
            end else begin
                if (pending) begin
                    mem_rsp_valid = 1'b1; mem_rsp_data = pte; pending = 0;
                end
                if (mem_req_valid) begin
                    got_reads++; got_addr = mem_req_addr; pending = 1;
                    ready_in_fetch = ready_in_fetch | req_ready;
                    if (poke) begin
                        cfg_we = 1'b1; cfg_region = va[31:30]; cfg_is_len = 1'b0; cfg_wdata = poke_base;
                    end
                end
            end
        end
    endtask

    task automatic expect_ok(input string req, input int reads, input logic [29:0] pa);
        check(req, 64'(got_reads), 64'(reads));
        check(req, 64'(got_code), 64'd0);
        check(req, 64'(got_pa), 64'(pa));
        check(req, 64'(got_lat), (reads != 0) ? 64'd3 : 64'd1);
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12", 64'(req_ready), 64'd1);
        check("R12", 64'(rsp_done), 64'd0);
        check("R12", 64'(mem_req_valid), 64'd0);

        cfg_write(2'd0, 1'b0, 32'h0001_0000);
        cfg_write(2'd0, 1'b1, 32'd16);
        cfg_write(2'd1, 1'b0, 32'h0002_0000);
        cfg_write(2'd1, 1'b1, 32'h001F_FFF0);
        cfg_write(2'd2, 1'b0, 32'h0003_0000);
        cfg_write(2'd2, 1'b1, 32'd8);

        for (int v = 0; v < NV; v++) begin
            xlate(VEC[v][129:98], VEC[v][97:66], 1'b0, '0);
            check(TAG[v], 64'(got_reads), 64'(VEC[v][65:64]));
            check(TAG[v], 64'(got_code), 64'(VEC[v][31:30]));
            check(TAG[v], 64'(got_lat), (VEC[v][65:64] != 0) ? 64'd3 : 64'd1);
            if (VEC[v][65:64] != 0) check(TAG[v], 64'(got_addr), 64'(VEC[v][63:32]));
            if (VEC[v][31:30] == 2'd0) check(TAG[v], 64'(got_pa), 64'(VEC[v][29:0]));
        end

        // R11 round robin with four entries: fifth fill evicts first page
        xlate(32'h0000_0200, 32'h8000_0007, 1'b0, '0);
        expect_ok("R11", 1, 30'h0000_0E00);
        xlate(32'h0000_0A00, 32'h8000_0123, 1'b0, '0);
        expect_ok("R11", 1, 30'h0002_4600);
        xlate(32'h7FFF_E000, 32'h8000_0001, 1'b0, '0);
        expect_ok("R11", 0, 30'h0000_0200);

        // R9 register write drops only its own region
        cfg_write(2'd2, 1'b1, 32'd8);
        xlate(32'h7FFF_E000, 32'h8000_0001, 1'b0, '0);
        expect_ok("R9", 0, 30'h0000_0200);
        xlate(32'h8000_0E10, 32'h8FFF_FFFF, 1'b0, '0);
        expect_ok("R9", 1, 30'h3FFF_FE10);
        cfg_write(2'd0, 1'b0, 32'h0004_0000);
        xlate(32'h0000_0200, 32'h8000_0009, 1'b0, '0);
        expect_ok("R9", 1, 30'h0000_1200);
        check("R5", 64'(got_addr), 64'h0004_0004);

        // R10 write during outstanding read: delivered but not cached
        xlate(32'h0000_0400, 32'h8000_0011, 1'b1, 32'h0004_0000);
        expect_ok("R10", 1, 30'h0000_2200);
        check("R10", 64'(got_addr), 64'h0004_0008);
        xlate(32'h0000_0400, 32'h8000_0011, 1'b0, '0);
        expect_ok("R10", 1, 30'h0000_2200);

        check("R12", 64'(ready_in_fetch), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule